// File: doc/BRIEF.md
# Word/Byte Beat Splitter

This engine turns one buffer transfer request into a series of write beats aimed at a single fixed destination register. The request gives a start address and a length in bytes. The engine emits the read address of each beat, together with a flag that says whether the beat moves a full 32-bit word or a single byte. It waits on a valid/ready handshake with the destination before it moves to the next beat, and it raises a one-cycle completion pulse at the end of the request.

The buffer is always cut into two runs. The first run is the largest whole number of 4-byte words that fits in the length. The second run holds whatever is left over, which is zero to three bytes, and each of those bytes is sent as its own narrow beat. A destination queue that accepts word-sized pushes can then take most of the payload at full width, and only the tail falls back to byte accesses.

Top module: `beat_splitter`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `beatValid` and `xferDone` are both low.
- R2: A request of length L produces exactly floor(L/4) word beats (`beatWide`=1). The first word beat is at the start address, and each later word beat is 4 above the one before it.
- R3: After the word beats, L mod 4 byte beats (`beatWide`=0) follow. The first byte beat is at start + 4*floor(L/4), and each later byte beat is 1 above the one before it.
- R4: No word beat ever follows a byte beat within a request. All word beats finish before the first byte beat.
- R5: A length of 1 to 3 produces no word beat. The first beat is a byte beat at the start address.
- R6: A nonzero length that is a multiple of 4 produces no byte beat.
- R7: A length of zero produces no beat, and `xferDone` is high in the cycle right after the cycle in which `startReq` was sampled.
- R8: While `beatValid` is high and `beatReady` is low, the beat's address and width stay unchanged into the next cycle.
- R9: `xferDone` is high for exactly one cycle, in the cycle right after the last beat is accepted, and never in the same cycle as `beatValid`.
- R10: A `startReq` raised while a request is in progress (beats pending or completion pulse showing) is ignored. It does not change the running sequence, and no new beats follow the completion pulse.
- R11: With `beatReady` held high, one beat is accepted every cycle, so a request of N beats shows its completion pulse N cycles after the first beat appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request strobe, taken only when idle |
| baseAddr | input | AW | Buffer start address, captured with the request |
| byteLen | input | LW | Buffer length in bytes, captured with the request |
| beatValid | output | 1 | A beat is being offered |
| beatReady | input | 1 | Destination accepts the offered beat |
| beatAddr | output | AW | Read address of the offered beat |
| beatWide | output | 1 | 1 = 32-bit word beat, 0 = single-byte beat |
| xferDone | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
Two events can land on the same clock edge. One is acceptance of the last word beat, which moves the engine straight into either the byte run or the completion pulse. The other is a fresh `startReq` arriving while the engine is busy. The bench raises a second request in the middle of a transfer, and it also runs lengths that end exactly on a word boundary and lengths with a tail. After each run it checks that the address sequence, the width flags and the completion cycle match the values computed from the length alone. It also checks that the extra request leaves no trace once the pulse has passed.

// File: rtl/beat_split_pkg.sv
package beat_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORD = 2'd1,
    ST_BYTE = 2'd2,
    ST_FIN  = 2'd3
  } splitState_t;

  // Strobes from the control FSM into the address/count datapath
  typedef struct packed {
    logic load;
    logic stepWord;
    logic stepByte;
  } dpCtl_t;

endpackage

// File: rtl/beat_split_dpath.sv
module beat_split_dpath
  import beat_split_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] baseAddr,
  input  logic [LW-1:0] byteLen,
  output logic [AW-1:0] curAddr,
  output logic          lenHasWords,
  output logic          lenHasBytes,
  output logic          wordLast,
  output logic          byteLast,
  output logic          bytesPending
);

  localparam int WORD_BYTES = 4;
  localparam int TAIL_W     = $clog2(WORD_BYTES);
  localparam int WCW        = LW - TAIL_W;

  logic [WCW-1:0]    wordLeft;
  logic [TAIL_W-1:0] byteLeft;

  // Classification of a new request, seen by control before the load
  assign lenHasWords  = |byteLen[LW-1:TAIL_W];
  assign lenHasBytes  = |byteLen[TAIL_W-1:0];
  assign wordLast     = (wordLeft == WCW'(1));
  assign byteLast     = (byteLeft == TAIL_W'(1));
  assign bytesPending = (byteLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      wordLeft <= '0;
      byteLeft <= '0;
    end else if (ctl.load) begin
      curAddr  <= baseAddr;
      wordLeft <= byteLen[LW-1:TAIL_W];
      byteLeft <= byteLen[TAIL_W-1:0];
    end else if (ctl.stepWord) begin
      curAddr  <= curAddr + AW'(WORD_BYTES);
      wordLeft <= wordLeft - WCW'(1);
    end else if (ctl.stepByte) begin
      curAddr  <= curAddr + AW'(1);
      byteLeft <= byteLeft - TAIL_W'(1);
    end
  end

  // R2
  word_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepWord |-> (wordLeft != '0));

  // R3
  byte_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepByte |-> (byteLeft != '0));

endmodule

// File: rtl/beat_split_ctrl.sv
module beat_split_ctrl
  import beat_split_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   beatReady,
  input  logic   lenHasWords,
  input  logic   lenHasBytes,
  input  logic   wordLast,
  input  logic   byteLast,
  input  logic   bytesPending,
  output dpCtl_t ctl,
  output logic   beatValid,
  output logic   beatWide,
  output logic   xferDone
);

  splitState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    ctl    = '0;
    unique case (st)
      ST_IDLE: begin
        if (startReq) begin
          ctl.load = 1'b1;
          if (lenHasWords)      stNext = ST_WORD;
          else if (lenHasBytes) stNext = ST_BYTE;
          else                  stNext = ST_FIN;
        end
      end
      ST_WORD: begin
        if (beatReady) begin
          ctl.stepWord = 1'b1;
          if (wordLast) stNext = bytesPending ? ST_BYTE : ST_FIN;
        end
      end
      ST_BYTE: begin
        if (beatReady) begin
          ctl.stepByte = 1'b1;
          if (byteLast) stNext = ST_FIN;
        end
      end
      ST_FIN:  stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  assign beatValid = (st == ST_WORD) || (st == ST_BYTE);
  assign beatWide  = (st == ST_WORD);
  assign xferDone  = (st == ST_FIN);

  // R8
  hold_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> (beatValid && $stable(beatWide)));

  // R4
  word_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatWide) |=> !(beatValid && beatWide));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && startReq && !lenHasWords && !lenHasBytes) |=> xferDone);

endmodule

// File: rtl/beat_splitter.sv
module beat_splitter
  import beat_split_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [AW-1:0] baseAddr,
  input  logic [LW-1:0] byteLen,
  output logic          beatValid,
  input  logic          beatReady,
  output logic [AW-1:0] beatAddr,
  output logic          beatWide,
  output logic          xferDone
);

  dpCtl_t ctl;
  logic   lenHasWords, lenHasBytes, wordLast, byteLast, bytesPending;

  beat_split_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .beatReady    (beatReady),
    .lenHasWords  (lenHasWords),
    .lenHasBytes  (lenHasBytes),
    .wordLast     (wordLast),
    .byteLast     (byteLast),
    .bytesPending (bytesPending),
    .ctl          (ctl),
    .beatValid    (beatValid),
    .beatWide     (beatWide),
    .xferDone     (xferDone)
  );

  beat_split_dpath #(.AW(AW), .LW(LW)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .baseAddr     (baseAddr),
    .byteLen      (byteLen),
    .curAddr      (beatAddr),
    .lenHasWords  (lenHasWords),
    .lenHasBytes  (lenHasBytes),
    .wordLast     (wordLast),
    .byteLast     (byteLast),
    .bytesPending (bytesPending)
  );

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatReady) |=> $stable(beatAddr));

  // R2
  word_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && beatWide) |=>
      (!beatValid || beatAddr == $past(beatAddr) + AW'(4)));

  // R3
  byte_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && !beatWide) |=>
      (!beatValid || beatAddr == $past(beatAddr) + AW'(1)));

  // R9
  done_no_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !beatValid);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && startReq) |=> (beatValid || xferDone));

endmodule

// File: tb/sim_beat_splitter.sv
`timescale 1ns/1ps
module sim_beat_splitter;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          beatReady = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic [LW-1:0] byteLen = '0;
  logic          beatValid, beatWide, xferDone;
  logic [AW-1:0] beatAddr;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  beat_splitter #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .baseAddr(baseAddr),
    .byteLen(byteLen), .beatValid(beatValid), .beatReady(beatReady),
    .beatAddr(beatAddr), .beatWide(beatWide), .xferDone(xferDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request, checked beat by beat. stallMod=0 keeps ready high.
  task automatic runXfer(input logic [AW-1:0] base, input int len, input int stallMod, input bit poke);
    int nW = len / 4;
    int nB = len % 4;
    int total = nW + nB;
    int k = 0;
    int cyc = 0;
    bit lastAcc = 1'b0;
    bit prevStall = 1'b0;
    bit gotDone = 1'b0;
    logic [AW-1:0] prevAddr = '0;
    logic prevWide = 1'b0;
    @(negedge clk);
    startReq = 1'b1; baseAddr = base; byteLen = LW'(len);
    @(negedge clk);
    startReq = 1'b0;
    while (!gotDone && cyc < 400) begin
      if (poke) begin
        if (cyc == 1) begin startReq = 1'b1; baseAddr = 32'hDEAD0000; byteLen = LW'(5); end
        else startReq = 1'b0;
      end
      if (prevStall)
        check(beatValid && beatAddr == prevAddr && beatWide == prevWide, "R8 stalled beat held", beatAddr, prevAddr);
      if (xferDone) begin
        gotDone = 1'b1;
        check(k == total, "R9 all beats before done", k, total);
        check(!beatValid, "R9 no beat with done", beatValid, 0);
        if (total == 0) check(cyc == 0, "R7 zero length done cycle", cyc, 0);
        else            check(lastAcc, "R9 done right after last beat", lastAcc, 1);
        if (stallMod == 0) check(cyc == total, "R11 back-to-back done cycle", cyc, total);
        beatReady = 1'b0;
        prevStall = 1'b0;
      end else if (beatValid) begin
        if (k >= total) begin
          check(1'b0, "R2 unexpected extra beat", k, total);
        end else if (k < nW) begin
          check(beatWide == 1'b1, "R2 word beat width", beatWide, 1);
          check(beatAddr == base + AW'(4 * k), "R2 word beat address", beatAddr, base + AW'(4 * k));
        end else begin
          check(beatWide == 1'b0, "R4 byte beat after words", beatWide, 0);
          check(beatAddr == base + AW'(4 * nW + (k - nW)), "R3 byte beat address",
                beatAddr, base + AW'(4 * nW + (k - nW)));
        end
        beatReady = (stallMod == 0) || ((cyc % stallMod) != 0);
        lastAcc = beatReady;
        prevStall = !beatReady;
        prevAddr = beatAddr;
        prevWide = beatWide;
        if (beatReady) k++;
      end else begin
        beatReady = 1'b0;
        lastAcc = 1'b0;
        prevStall = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    if (!gotDone) check(1'b0, "R9 done never seen", cyc, 0);
    startReq = 1'b0;
    beatReady = 1'b0;
    check(!xferDone, "R9 done lasts one cycle", xferDone, 0);
    for (int i = 0; i < 3; i++) begin
      check(!beatValid && !xferDone, "R10 quiet after done", beatValid, 0);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!beatValid && !xferDone, "R1 outputs low in reset", {beatValid, xferDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!beatValid && !xferDone, "R1 outputs low after reset", {beatValid, xferDone}, 0);
  endtask

  // R2 R3 R4 R11: words then tail, no stall
  task automatic testMixed();    runXfer(32'h0000_1000, 11, 0, 1'b0); endtask
  // R6 R8: multiple of four with stalls
  task automatic testWordsOnly(); runXfer(32'h0000_2000, 8, 3, 1'b0); endtask
  // R5: tail only, odd address
  task automatic testTailOnly();  runXfer(32'h0000_2001, 3, 0, 1'b0); endtask
  // R7
  task automatic testZero();      runXfer(32'h0000_4000, 0, 0, 1'b0); endtask
  // R10: start raised mid-transfer, with stalls
  task automatic testBusyStart(); runXfer(32'h0000_5000, 9, 2, 1'b1); endtask
  // Boundary lengths
  task automatic testEdges();
    runXfer(32'h0000_6000, 1, 0, 1'b0);
    runXfer(32'h0000_7000, 4, 0, 1'b0);
    runXfer(32'h0000_3002, 7, 4, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testMixed();
    testWordsOnly();
    testTailOnly();
    testZero();
    testBusyStart();
    testEdges();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule